// File: doc/BRIEF.md
# Mono Codec Serial Link Controller

This block drives a four-wire synchronous serial link to a 16-bit mono audio codec that runs as a slave. It divides the system clock down to a bit clock and a frame sync, so no second clock source is needed. In every frame it shifts one playback sample out to the codec and shifts one record sample in. Both samples are sixteen-bit two's complement values, sent most significant bit first. Outgoing data changes only when the bit clock falls. Incoming data is sampled when the bit clock rises.

The playback side is a valid/ready stream. `play_ready` pulses for one system cycle once per frame, and a word moves in the cycle where `play_valid` and `play_ready` are both high. A producer that raises `play_valid` must hold it and `play_data` steady until that cycle. If no word is waiting when the pulse comes, the frame carries zero and no word is consumed. The record side has no back-pressure: `rec_valid` pulses for one cycle with the word just assembled, and the consumer must take it in that cycle.

The divider setting `cfg_half_cycles` is the number of system clocks in each bit clock phase. It is set so that the codec's minimum bit clock period and phase widths are met, and it is changed only while reset is held.

Top module: `codec_serial_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle has `link_bck`, `link_fs`, `link_sdo`, `play_ready` and `rec_valid` all low.
- R2: Each high phase and each low phase of `link_bck` lasts exactly `cfg_half_cycles` system clocks. A setting of 0 acts as 1.
- R3: `link_fs` rises and falls only in cycles where `link_bck` falls. It stays high for one bit period (2·`cfg_half_cycles` clocks), and its rising edges are 16 bit periods apart.
- R4: `link_sdo` changes only in cycles where `link_bck` falls.
- R5: A playback word is sent on `link_sdo` bit 15 first and bit 0 last, in the 16 bit periods that follow the rising `link_bck` edge at which `link_fs` is high. Each bit is valid at its rising `link_bck` edge.
- R6: `play_ready` is a single-cycle pulse, once per frame. It occurs while `link_fs` and `link_bck` are both high, just before the falling edge that launches bit 15. A word is accepted only in a cycle where `play_valid` and `play_ready` are both high.
- R7: If `play_valid` is low during the `play_ready` pulse, that frame sends 0x0000.
- R8: `link_sdi` is sampled at each rising `link_bck` edge, bit 15 first. After bit 0 is sampled, `rec_valid` pulses for one cycle with the assembled word. No pulse is produced for the partial frame before the first playback slot after reset.
- R9: After reset is released, the first rising edge of `link_bck` comes `cfg_half_cycles` clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_half_cycles | input | DIV_W | System clocks per bit clock phase |
| play_valid | input | 1 | Playback word offered |
| play_data | input | SAMPLE_W | Playback word, two's complement |
| play_ready | output | 1 | One-cycle accept window, once per frame |
| rec_valid | output | 1 | Record word valid, one-cycle pulse |
| rec_data | output | SAMPLE_W | Record word, two's complement |
| link_bck | output | 1 | Bit clock to the codec |
| link_fs | output | 1 | Frame sync to the codec |
| link_sdo | output | 1 | Serial playback data to the codec |
| link_sdi | input | 1 | Serial record data from the codec |

## Verification
The hardest cases to reach are a frame whose accept pulse arrives while the producer is idle, and a producer that waits a long time with its word held. The driver reaches both. It leaves whole frames with `play_valid` low, which must produce zero frames, and it raises `play_valid` far ahead of the accept pulse and holds it there. The frame boundary is a second hard case: the last playback bit and the next frame sync share one bit period. A behavioural codec model therefore follows the frame sync at its own rising edges, runs back to back with the design, and is exercised at both a slow divider setting and the fastest one.

// File: rtl/codec_link_pkg.sv
package codec_link_pkg;
  // Per-cycle strobes marking bit clock transitions taken at this clock edge.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_ev_t;
endpackage

// File: rtl/cslk_divider.sv
module cslk_divider
  import codec_link_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_cycles,
  output logic             bck,
  output edge_ev_t         ev
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   cnt_inc;
  logic             tick;

  always_comb begin
    cnt_inc = {1'b0, cnt} + 1'b1;
    // A setting of 0 ticks every cycle, exactly like 1.
    tick    = (cnt_inc >= {1'b0, half_cycles});
    ev.rise = tick && !bck;
    ev.fall = tick && bck;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      bck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      bck <= ~bck;
    end else begin
      cnt <= cnt_inc[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/cslk_framer.sv
module cslk_framer
  import codec_link_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  edge_ev_t ev,
  output logic     fs,
  output logic     load_now,
  output logic     lsb_rise
);
  localparam int SLOT_W = $clog2(SAMPLE_W);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SAMPLE_W - 1);

  // Slot index, advanced at each falling bit clock; slot 0 carries the LSB and the sync.
  logic [SLOT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= LAST;
      fs   <= 1'b0;
    end else if (ev.fall) begin
      if (slot == LAST) begin
        slot <= '0;
        fs   <= 1'b1;
      end else begin
        slot <= slot + 1'b1;
        fs   <= 1'b0;
      end
    end
  end

  assign load_now = ev.fall && (slot == '0);
  assign lsb_rise = ev.rise && (slot == '0);
endmodule

// File: rtl/cslk_tx.sv
module cslk_tx #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_now,
  input  logic                fall,
  input  logic                play_valid,
  input  logic [SAMPLE_W-1:0] play_data,
  output logic                play_ready,
  output logic                sdo
);
  logic [SAMPLE_W-1:0] sreg;
  logic [SAMPLE_W-1:0] word;

  assign play_ready = load_now;
  assign word       = play_valid ? play_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      sdo  <= 1'b0;
    end else if (load_now) begin
      sdo  <= word[SAMPLE_W-1];
      sreg <= {word[SAMPLE_W-2:0], 1'b0};
    end else if (fall) begin
      sdo  <= sreg[SAMPLE_W-1];
      sreg <= {sreg[SAMPLE_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/cslk_rx.sv
module cslk_rx #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise,
  input  logic                lsb_rise,
  input  logic                load_now,
  input  logic                sdi,
  output logic                rec_valid,
  output logic [SAMPLE_W-1:0] rec_data
);
  logic [SAMPLE_W-1:0] sreg;
  logic                armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg      <= '0;
      armed     <= 1'b0;
      rec_valid <= 1'b0;
      rec_data  <= '0;
    end else begin
      rec_valid <= 1'b0;
      if (load_now) armed <= 1'b1;
      if (rise) begin
        sreg <= {sreg[SAMPLE_W-2:0], sdi};
        if (lsb_rise && armed) begin
          rec_data  <= {sreg[SAMPLE_W-2:0], sdi};
          rec_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/codec_serial_ctrl.sv
module codec_serial_ctrl
  import codec_link_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    cfg_half_cycles,
  input  logic                play_valid,
  input  logic [SAMPLE_W-1:0] play_data,
  output logic                play_ready,
  output logic                rec_valid,
  output logic [SAMPLE_W-1:0] rec_data,
  output logic                link_bck,
  output logic                link_fs,
  output logic                link_sdo,
  input  logic                link_sdi
);
  edge_ev_t ev;
  logic     load_now;
  logic     lsb_rise;

  cslk_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .half_cycles(cfg_half_cycles), .bck(link_bck), .ev(ev)
  );

  cslk_framer #(.SAMPLE_W(SAMPLE_W)) u_frm (
    .clk(clk), .rst(rst), .ev(ev), .fs(link_fs), .load_now(load_now), .lsb_rise(lsb_rise)
  );

  cslk_tx #(.SAMPLE_W(SAMPLE_W)) u_tx (
    .clk(clk), .rst(rst), .load_now(load_now), .fall(ev.fall),
    .play_valid(play_valid), .play_data(play_data), .play_ready(play_ready), .sdo(link_sdo)
  );

  cslk_rx #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk(clk), .rst(rst), .rise(ev.rise), .lsb_rise(lsb_rise), .load_now(load_now),
    .sdi(link_sdi), .rec_valid(rec_valid), .rec_data(rec_data)
  );
endmodule

// File: rtl/cslk_checker.sv
module cslk_checker (
  input logic clk,
  input logic rst,
  input logic bck,
  input logic fs,
  input logic sdo,
  input logic play_ready,
  input logic rec_valid
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!bck && !fs && !sdo && !play_ready && !rec_valid));

  a_r3_fs_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(fs) |-> ($past(bck) && !bck));

  a_r4_sdo_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> ($past(bck) && !bck));

  a_r6_ready_single: assert property (@(posedge clk) disable iff (rst)
    play_ready |=> !play_ready);

  a_r6_ready_in_sync: assert property (@(posedge clk) disable iff (rst)
    play_ready |-> (fs && bck));

  a_r8_rec_single: assert property (@(posedge clk) disable iff (rst)
    rec_valid |=> !rec_valid);
endmodule

bind codec_serial_ctrl cslk_checker u_cslk_chk (
  .clk(clk), .rst(rst), .bck(link_bck), .fs(link_fs), .sdo(link_sdo),
  .play_ready(play_ready), .rec_valid(rec_valid)
);

// File: tb/codec_serial_ctrl_tb_top.sv
module codec_serial_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  half;
  logic        play_valid;
  logic [15:0] play_data;
  logic        play_ready, rec_valid, link_bck, link_fs, link_sdo;
  logic [15:0] rec_data;
  logic        link_sdi = 1'b0;

  always #5 clk = ~clk;

  codec_serial_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_half_cycles(half), .play_valid(play_valid),
    .play_data(play_data), .play_ready(play_ready), .rec_valid(rec_valid),
    .rec_data(rec_data), .link_bck(link_bck), .link_fs(link_fs),
    .link_sdo(link_sdo), .link_sdi(link_sdi)
  );

  int n_chk = 0, n_fail = 0;
  int play_cmp = 0, rec_cmp = 0, zero_cmp = 0;
  logic [15:0] play_q[$];
  logic [15:0] rec_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Codec model: samples at rising bit clock, drives at falling bit clock.
  bit          c_rx_on = 0, c_tx_on = 0;
  int          c_rx_n = 0, c_tx_n = 0, c_idx = 0;
  logic [15:0] c_rx_w = '0, c_tx_w = '0;

  function automatic logic [15:0] rec_word(input int i);
    if (i % 5 == 1) return 16'h8000;
    if (i % 5 == 3) return 16'h7FFF;
    return 16'(i * 16'h3B5D) ^ 16'hC3A1;
  endfunction

  always @(posedge link_bck) begin
    if (!rst) begin
      if (c_rx_on) begin
        c_rx_w = {c_rx_w[14:0], link_sdo};
        c_rx_n++;
        if (c_rx_n == 16) begin
          logic [15:0] e;
          c_rx_on = 0;
          if (play_q.size() == 0) begin
            check(0, "R5", "frame with no expected word", c_rx_w, 0);
          end else begin
            e = play_q.pop_front();
            if (e == 16'h0) begin
              zero_cmp++;
              check(c_rx_w == e, "R7", "idle frame word", c_rx_w, e);
            end else begin
              check(c_rx_w == e, "R5", "playback word", c_rx_w, e);
            end
            play_cmp++;
          end
        end
      end
      if (link_fs) begin
        c_rx_on = 1; c_rx_n = 0; c_rx_w = '0;
        c_tx_on = 1; c_tx_n = 0;
        c_tx_w  = rec_word(c_idx);
        c_idx++;
        rec_q.push_back(c_tx_w);
      end
    end
  end

  always @(negedge link_bck) begin
    if (rst) begin
      c_tx_on = 0; c_rx_on = 0; link_sdi = 1'b0;
    end else if (c_tx_on) begin
      link_sdi = c_tx_w[15 - c_tx_n];
      c_tx_n++;
      if (c_tx_n == 16) c_tx_on = 0;
    end
  end

  // Scoreboard monitor and port timing checks, sampled at negedge clk.
  logic prev_bck = 0, prev_fs = 0, prev_sdo = 0, prev_ready = 0, prev_rv = 0;
  int   bck_run = 0, fs_run = 0, since_rise = 0;
  bit   have_rise = 0, first_run = 1;

  always @(negedge clk) begin
    if (rst) begin
      prev_bck = 0; prev_fs = 0; prev_sdo = 0; prev_ready = 0; prev_rv = 0;
      bck_run = 0; fs_run = 0; since_rise = 0; have_rise = 0; first_run = 1;
    end else begin
      int h;
      h = (half == 0) ? 1 : int'(half);
      if (play_ready) play_q.push_back(play_valid ? play_data : 16'h0);
      if (play_ready && prev_ready) check(0, "R6", "ready wider than one cycle", 2, 1);
      if (rec_valid) begin
        if (prev_rv) check(0, "R8", "rec_valid wider than one cycle", 2, 1);
        if (rec_q.size() == 0) check(0, "R8", "rec_valid with nothing sent", rec_data, 0);
        else begin
          logic [15:0] e;
          e = rec_q.pop_front();
          check(rec_data == e, "R8", "record word", rec_data, e);
          rec_cmp++;
        end
      end
      if (link_bck == prev_bck) bck_run++;
      else begin
        if (first_run) check(bck_run == h, "R9", "first low phase", bck_run, h);
        else           check(bck_run == h, "R2", "bit clock phase", bck_run, h);
        first_run = 0;
        bck_run = 1;
      end
      if (link_sdo != prev_sdo)
        check(prev_bck && !link_bck, "R4", "sdo moved off a falling edge", link_bck, 0);
      if (link_fs) fs_run++;
      if (prev_fs && !link_fs) begin
        check(fs_run == 2 * h, "R3", "frame sync width", fs_run, 2 * h);
        fs_run = 0;
      end
      if (link_fs && !prev_fs) begin
        check(prev_bck && !link_bck, "R3", "frame sync rose off a falling edge", link_bck, 0);
        if (have_rise) check(since_rise == 32 * h, "R3", "frame period", since_rise, 32 * h);
        have_rise = 1;
        since_rise = 1;
      end else since_rise++;
      prev_bck = link_bck; prev_fs = link_fs; prev_sdo = link_sdo;
      prev_ready = play_ready; prev_rv = rec_valid;
    end
  end

  // Driver: raise valid early and hold it until the accept pulse (back-pressure).
  task automatic send(input logic [15:0] w);
    @(posedge clk); #1;
    play_valid = 1'b1;
    play_data  = w;
    forever begin
      @(negedge clk);
      if (play_ready) break;
    end
    @(posedge clk); #1;
    play_valid = 1'b0;
    play_data  = 16'hDEAD;
  endtask

  task automatic idle_frames(input int n);
    repeat (n * 32 * ((half == 0) ? 1 : int'(half))) @(posedge clk);
  endtask

  task automatic do_reset(input logic [7:0] h);
    rst = 1'b1;
    half = h;
    play_valid = 1'b1;
    play_data = 16'hBEEF;
    repeat (3) @(posedge clk);
    repeat (3) begin
      @(negedge clk);
      check(!link_bck && !link_fs && !link_sdo, "R1", "link pins in reset",
            {link_bck, link_fs, link_sdo}, 0);
      check(!play_ready && !rec_valid, "R1", "handshake pins in reset",
            {play_ready, rec_valid}, 0);
    end
    play_q.delete();
    rec_q.delete();
    c_rx_on = 0; c_tx_on = 0;
    play_valid = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  bit done = 0;

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    do_reset(8'd3);
    send(16'h1234);
    send(16'h8000);
    idle_frames(2);
    send(16'h7FFF);
    send(16'hFFFF);
    send(16'h0001);
    send(16'hA5A5);
    idle_frames(3);
    check(play_cmp >= 8, "R5", "playback frames compared", play_cmp, 8);
    check(zero_cmp >= 2, "R7", "idle frames compared", zero_cmp, 2);
    check(rec_cmp >= 8, "R8", "record words compared", rec_cmp, 8);

    base = play_cmp;
    do_reset(8'd1);
    send(16'h0F0F);
    send(16'hC001);
    idle_frames(1);
    send(16'h5A5A);
    idle_frames(3);
    check(play_cmp - base >= 5, "R5", "fast divider frames compared", play_cmp - base, 5);

    do_reset(8'd0);
    send(16'h3C3C);
    idle_frames(2);

    done = 1;
    summary();
    $finish;
  end
endmodule